// File: doc/BRIEF.md
# Bus Write Watchpoint Logger

This block watches the write traffic of up to three bus sources: source 0 is the main CPU, source 1 the low-power CPU and source 2 the DMA engine. Each write is qualified against a per-source enable, an inclusive address window and a one-hot trigger mode. A qualified write produces a two-word record that goes into a ring region of memory through a simple write port. The ring is bounded by a programmable first and last record slot. Depending on a loop control input, the ring either wraps and overwrites old records or stops at its last slot.

Configuration arrives on plain input ports, which are driven by a register block outside this design. The block itself drives the memory write port, the address the next record will use, and a sticky full flag. One-cycle strobes reload the pointer and clear the flag.

A four-state machine orders the work. The states are:
- ST_IDLE: waiting for a trigger.
- ST_ADDR: writing the first record word.
- ST_INFO: writing the second record word.
- ST_HALT: stopped at the last slot with looping off.

The transitions are:
- ST_IDLE→ST_ADDR on a trigger.
- ST_ADDR→ST_INFO always.
- ST_INFO→ST_ADDR when a trigger arrives in that cycle.
- ST_INFO→ST_IDLE when no trigger arrives.
- ST_INFO→ST_HALT when the last slot was just written with looping off.
- Any state→ST_IDLE on a pointer reload.

Top module: `wp_logger`

## Requirements
- R1: A source whose bit in `cfg_src_en` is 0 (bit 0 main CPU, bit 1 low-power CPU, bit 2 DMA) never produces a record.
- R2: With `cfg_mode` = 4'b0001, any enabled, in-window write triggers a record, whatever its data and size.
- R3: With `cfg_mode` = 4'b0010, 4'b0100 or 4'b1000, a write triggers only if both of these hold:
  - its size code is word (2), halfword (1) or byte (0) respectively;
  - its 32-bit data equals `cfg_check` on every byte not excluded by the mask.
- R4: Bit b of `cfg_byte_mask` set removes data bits [8b+7:8b] from the comparison.
- R5: Only writes with `cfg_watch_lo` <= address <= `cfg_watch_hi` can trigger; both ends are inclusive.
- R6: A trigger accepted at clock edge N produces two memory writes.
  - In the cycle after N: the write address is `next_addr` and the data is the transaction address.
  - In the cycle after that: the write address is `next_addr`+4 and the data is the info word. The info word holds the source id in bits [1:0] and the size code in bits [5:4]; all other bits are 0.
- R7: After the second word, `next_addr` advances by 8. If the record just written sat at or beyond `cfg_store_end` and `cfg_wrap_en` is 1, `next_addr` returns to `cfg_store_start` instead.
- R8: `full_flag` is cleared by reset. It is set when a record at or beyond `cfg_store_end` completes, and clears only on `cfg_full_clr`. When both happen in the same cycle, the set wins.
- R9: With `cfg_wrap_en` 0, once a record at or beyond `cfg_store_end` completes, `next_addr` holds and no further record is written until a reload.
- R10: `cfg_ptr_reload` loads `next_addr` from `cfg_store_start` at the next edge. It abandons any record in progress and leaves the stopped state. A trigger in the same cycle is discarded. `next_addr` is 0 after reset.
- R11: If `cfg_mode` is not one-hot, or `cfg_src_en` is 0, no write triggers a record.
- R12: When several sources trigger together, the lowest source id wins and one record is emitted. A trigger is dropped while the first record word is being written. A trigger is accepted in the cycle the second word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 3 | Write strobe per source |
| src_addr | input | 96 | Write address per source, source s in bits [32s+31:32s] |
| src_data | input | 96 | Write data per source, same packing |
| src_size | input | 6 | Size code per source (0 byte, 1 halfword, 2 word), bits [2s+1:2s] |
| cfg_src_en | input | 3 | Per-source logging enable |
| cfg_mode | input | 4 | One-hot trigger mode |
| cfg_check | input | 32 | Check value |
| cfg_byte_mask | input | 4 | Byte exclusion mask for the check |
| cfg_watch_lo | input | 32 | Lowest watched address |
| cfg_watch_hi | input | 32 | Highest watched address |
| cfg_store_start | input | 32 | First record slot of the ring |
| cfg_store_end | input | 32 | Last record slot of the ring |
| cfg_wrap_en | input | 1 | 1 wraps the ring, 0 stops at the end |
| cfg_ptr_reload | input | 1 | Strobe: reload pointer from start |
| cfg_full_clr | input | 1 | Strobe: clear the full flag |
| mem_we | output | 1 | Record memory write enable |
| mem_addr | output | 32 | Record memory byte address |
| mem_wdata | output | 32 | Record memory write data |
| next_addr | output | 32 | Address of the next record |
| full_flag | output | 1 | Sticky ring full indication |

## Verification
A corrupted state register or record capture shows up at the memory port within two cycles of a trigger:
- a missing second word;
- a second word at the wrong address;
- a record whose info word names the wrong source.

A wrong pointer or flag shows up on `next_addr` or `full_flag` at the edge that closes the record. From then on, every later record lands at a wrong slot, so a single fault in the ring logic keeps showing at the ports until the next reload.

// File: rtl/wp_logger_pkg.sv
package wp_logger_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_INFO = 2'd2,
        ST_HALT = 2'd3
    } wp_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int MODE_W    = 4;
    localparam int MB_ANY    = 0;
    localparam int MB_WORD   = 1;
    localparam int MB_HALF   = 2;
    localparam int MB_BYTE   = 3;

    localparam int SZW       = 2;
    localparam int INFO_SZ_LSB = 4;

endpackage

// File: rtl/wp_match.sv
module wp_match
    import wp_logger_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              enable,
    input  logic              valid,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    input  logic [SZW-1:0]    size,
    input  logic [MODE_W-1:0] mode,
    input  logic [DW-1:0]     check,
    input  logic [DW/8-1:0]   bmask,
    input  logic [AW-1:0]     lo,
    input  logic [AW-1:0]     hi,
    output logic              hit
);
    localparam int NB = DW / 8;

    logic [NB-1:0] byte_ok;
    logic          in_win;
    logic          mode_ok;
    logic          size_ok;
    logic          data_ok;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign byte_ok[b] = bmask[b] | (data[b*8 +: 8] == check[b*8 +: 8]);
    end

    always_comb begin
        in_win  = (addr >= lo) && (addr <= hi);
        mode_ok = $onehot(mode);
        size_ok = (mode[MB_WORD] && (size == SZ_WORD))
                | (mode[MB_HALF] && (size == SZ_HALF))
                | (mode[MB_BYTE] && (size == SZ_BYTE));
        data_ok = &byte_ok;
        hit     = enable && valid && in_win && mode_ok
                  && (mode[MB_ANY] || (size_ok && data_ok));
    end

endmodule

// File: rtl/wp_pick.sv
module wp_pick #(
    parameter int N  = 3,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wp_ring_ptr.sv
module wp_ring_ptr #(
    parameter int AW        = 32,
    parameter int REC_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    input  logic          wrap_en,
    input  logic          reload,
    input  logic          advance,
    input  logic          full_clr,
    output logic [AW-1:0] ptr,
    output logic          at_end,
    output logic          full
);
    logic [AW-1:0] ptr_nx;
    logic          full_set;

    always_comb begin
        at_end   = (ptr >= end_addr);
        full_set = advance && at_end;
        ptr_nx   = ptr;
        if (reload) begin
            ptr_nx = start_addr;
        end else if (advance) begin
            if (!at_end) begin
                ptr_nx = ptr + AW'(REC_BYTES);
            end else if (wrap_en) begin
                ptr_nx = start_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr  <= '0;
            full <= 1'b0;
        end else begin
            ptr <= ptr_nx;
            if (full_set) begin
                full <= 1'b1;
            end else if (full_clr) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wp_logger.sv
module wp_logger
    import wp_logger_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int AW   = 32,
    parameter int DW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_valid,
    input  logic [NSRC*AW-1:0]   src_addr,
    input  logic [NSRC*DW-1:0]   src_data,
    input  logic [NSRC*SZW-1:0]  src_size,
    input  logic [NSRC-1:0]      cfg_src_en,
    input  logic [MODE_W-1:0]    cfg_mode,
    input  logic [DW-1:0]        cfg_check,
    input  logic [DW/8-1:0]      cfg_byte_mask,
    input  logic [AW-1:0]        cfg_watch_lo,
    input  logic [AW-1:0]        cfg_watch_hi,
    input  logic [AW-1:0]        cfg_store_start,
    input  logic [AW-1:0]        cfg_store_end,
    input  logic                 cfg_wrap_en,
    input  logic                 cfg_ptr_reload,
    input  logic                 cfg_full_clr,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    output logic [AW-1:0]        next_addr,
    output logic                 full_flag
);
    localparam int NB        = DW / 8;
    localparam int REC_BYTES = 2 * NB;
    localparam int IDW       = (NSRC > 1) ? $clog2(NSRC) : 1;

    wp_state_e       state, state_nx;
    logic [NSRC-1:0] hit;
    logic            hit_any;
    logic [IDW-1:0]  hit_idx;
    logic            accept;
    logic            advance;
    logic            at_end;
    logic [AW-1:0]   ptr;
    logic [AW-1:0]   rec_addr;
    logic [DW-1:0]   rec_info;
    logic [DW-1:0]   info_nx;
    logic            first_phase;

    // Per-source qualification
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        wp_match #(.AW(AW), .DW(DW)) u_match (
            .enable (cfg_src_en[g]),
            .valid  (src_valid[g]),
            .addr   (src_addr[g*AW +: AW]),
            .data   (src_data[g*DW +: DW]),
            .size   (src_size[g*SZW +: SZW]),
            .mode   (cfg_mode),
            .check  (cfg_check),
            .bmask  (cfg_byte_mask),
            .lo     (cfg_watch_lo),
            .hi     (cfg_watch_hi),
            .hit    (hit[g])
        );
    end

    wp_pick #(.N(NSRC), .IW(IDW)) u_pick (
        .req (hit),
        .any (hit_any),
        .idx (hit_idx)
    );

    assign advance = (state == ST_INFO) && !cfg_ptr_reload;

    wp_ring_ptr #(.AW(AW), .REC_BYTES(REC_BYTES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (cfg_store_start),
        .end_addr   (cfg_store_end),
        .wrap_en    (cfg_wrap_en),
        .reload     (cfg_ptr_reload),
        .advance    (advance),
        .full_clr   (cfg_full_clr),
        .ptr        (ptr),
        .at_end     (at_end),
        .full       (full_flag)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and record acceptance
    always_comb begin
        state_nx = state;
        accept   = 1'b0;
        if (cfg_ptr_reload) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (hit_any) begin
                        accept   = 1'b1;
                        state_nx = ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    state_nx = ST_INFO;
                end
                ST_INFO: begin
                    if (at_end && !cfg_wrap_en) begin
                        state_nx = ST_HALT;
                    end else if (hit_any) begin
                        accept   = 1'b1;
                        state_nx = ST_ADDR;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
                ST_HALT: begin
                    state_nx = ST_HALT;
                end
            endcase
        end
    end

    // Info word of the winning source
    always_comb begin
        info_nx = '0;
        info_nx[IDW-1:0] = hit_idx;
        info_nx[INFO_SZ_LSB +: SZW] = src_size[hit_idx*SZW +: SZW];
    end

    // Record capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_addr <= '0;
            rec_info <= '0;
        end else if (accept) begin
            rec_addr <= src_addr[hit_idx*AW +: AW];
            rec_info <= info_nx;
        end
    end

    // Outputs
    always_comb begin
        mem_we      = 1'b0;
        mem_addr    = ptr;
        mem_wdata   = '0;
        first_phase = 1'b0;
        unique case (state)
            ST_ADDR: begin
                mem_we      = 1'b1;
                mem_addr    = ptr;
                mem_wdata   = DW'(rec_addr);
                first_phase = 1'b1;
            end
            ST_INFO: begin
                mem_we    = 1'b1;
                mem_addr  = ptr + AW'(NB);
                mem_wdata = rec_info;
            end
            ST_IDLE, ST_HALT: begin
                mem_we = 1'b0;
            end
        endcase
        next_addr = ptr;
    end

endmodule

// File: rtl/wp_logger_chk.sv
module wp_logger_chk #(
    parameter int AW = 32,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cfg_mode,
    input logic [2:0]    cfg_src_en,
    input logic          cfg_full_clr,
    input logic          cfg_ptr_reload,
    input logic [AW-1:0] cfg_store_start,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] next_addr,
    input logic          full_flag,
    input logic          first_phase
);
    // R6: first word is always followed by the second word one slot higher
    a_r6_second_word: assert property (@(posedge clk) disable iff (!rst_n)
        (first_phase && !cfg_ptr_reload) |=> (mem_we && (mem_addr == $past(mem_addr) + AW'(NB))));

    // R11: no new record may start while triggering is disabled
    a_r11_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_phase && (($countones(cfg_mode) != 1) || (cfg_src_en == 3'b000))) |=> !mem_we);

    // R7 / R10: the pointer only steps by one record or returns to start
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(next_addr) |-> ((next_addr == $past(cfg_store_start))
                                 || (next_addr == $past(next_addr) + AW'(2 * NB))));

    // R8: flag only falls on a clear strobe
    a_r8_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_flag) |-> $past(cfg_full_clr));

    // R8: flag only rises as a record completes
    a_r8_full_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_flag) |-> $past(mem_we));

endmodule

bind wp_logger wp_logger_chk #(.AW(AW), .NB(DW / 8)) u_wp_logger_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_mode        (cfg_mode),
    .cfg_src_en      (cfg_src_en),
    .cfg_full_clr    (cfg_full_clr),
    .cfg_ptr_reload  (cfg_ptr_reload),
    .cfg_store_start (cfg_store_start),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .next_addr       (next_addr),
    .full_flag       (full_flag),
    .first_phase     (first_phase)
);

// File: tb/tb_wp_logger.sv
`timescale 1ns/1ps
module tb_wp_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  v_in = '0;
    logic [31:0] a_in [3];
    logic [31:0] d_in [3];
    logic [1:0]  s_in [3];
    logic [2:0]  en = 3'b111;
    logic [3:0]  mode = 4'b0001;
    logic [31:0] chkv = '0;
    logic [3:0]  bmask = '0;
    logic [31:0] lo = '0, hi = '0, st = '0, en_a = '0;
    logic        wrap = 1'b1, reload = 1'b0, fclr = 1'b0;

    logic [95:0] src_addr, src_data;
    logic [5:0]  src_size;
    logic        mem_we, full_flag;
    logic [31:0] mem_addr, mem_wdata, next_addr;

    assign src_addr = {a_in[2], a_in[1], a_in[0]};
    assign src_data = {d_in[2], d_in[1], d_in[0]};
    assign src_size = {s_in[2], s_in[1], s_in[0]};

    always #4 clk = ~clk;

    wp_logger dut (
        .clk(clk), .rst_n(rst_n),
        .src_valid(v_in), .src_addr(src_addr), .src_data(src_data), .src_size(src_size),
        .cfg_src_en(en), .cfg_mode(mode), .cfg_check(chkv), .cfg_byte_mask(bmask),
        .cfg_watch_lo(lo), .cfg_watch_hi(hi), .cfg_store_start(st), .cfg_store_end(en_a),
        .cfg_wrap_en(wrap), .cfg_ptr_reload(reload), .cfg_full_clr(fclr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .next_addr(next_addr), .full_flag(full_flag)
    );

    int n_chk = 0, n_bad = 0, we_cnt = 0;
    bit done = 1'b0;
    string tag = "R6";

    // reference model state: 0 idle, 1 first word, 2 second word, 3 halted
    int          mst = 0;
    logic [31:0] mptr = '0, mra = '0, mri = '0;
    logic        mfull = 1'b0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit m_hit(int s);
        if (!en[s] || !v_in[s]) return 1'b0;
        if (a_in[s] < lo || a_in[s] > hi) return 1'b0;
        if ($countones(mode) != 1) return 1'b0;
        if (mode == 4'b0001) return 1'b1;
        for (int b = 0; b < 4; b++)
            if (!bmask[b] && (d_in[s][b*8 +: 8] != chkv[b*8 +: 8])) return 1'b0;
        return (mode == 4'b0010 && s_in[s] == 2'd2) || (mode == 4'b0100 && s_in[s] == 2'd1)
            || (mode == 4'b1000 && s_in[s] == 2'd0);
    endfunction

    task automatic m_capture(int w);
        mra = a_in[w];
        mri = (32'(s_in[w]) << 4) | 32'(w);
        mst = 1;
    endtask

    task automatic m_update();
        int w = 0;
        bit any = 1'b0, fset = 1'b0;
        for (int s = 2; s >= 0; s--) if (m_hit(s)) begin any = 1'b1; w = s; end
        if (reload) begin
            mst = 0; mptr = st;
        end else begin
            case (mst)
                0: if (any) m_capture(w);
                1: mst = 2;
                2: begin
                    if (mptr >= en_a) begin
                        fset = 1'b1;
                        if (wrap) mptr = st; else mst = 3;
                    end else mptr = mptr + 32'd8;
                    if (mst != 3) begin
                        if (any) m_capture(w); else mst = 0;
                    end
                end
                default: ;
            endcase
        end
        mfull = fset ? 1'b1 : (fclr ? 1'b0 : mfull);
    endtask

    // compare outputs with model, advance model, cross one clock edge
    task automatic step();
        chk(tag, "mem_we", 32'(mem_we), 32'(mst == 1 || mst == 2));
        if (mst == 1) begin
            chk(tag, "mem_addr w0", mem_addr, mptr);
            chk(tag, "mem_wdata w0", mem_wdata, mra);
        end else if (mst == 2) begin
            chk(tag, "mem_addr w1", mem_addr, mptr + 32'd4);
            chk(tag, "mem_wdata w1", mem_wdata, mri);
        end
        chk(tag, "next_addr", next_addr, mptr);
        chk(tag, "full_flag", 32'(full_flag), 32'(mfull));
        if (mem_we) we_cnt++;
        m_update();
        @(negedge clk);
        reload = 1'b0;
        fclr = 1'b0;
    endtask

    task automatic wr(int s, logic [31:0] ad, logic [31:0] da, logic [1:0] sz);
        v_in = '0; v_in[s] = 1'b1; a_in[s] = ad; d_in[s] = da; s_in[s] = sz;
        step();
        v_in = '0;
        repeat (3) step();
    endtask

    task automatic do_reload();
        reload = 1'b1;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 3; s++) begin a_in[s] = '0; d_in[s] = '0; s_in[s] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // reset state (R10, R8)
        chk("R10", "reset next_addr", next_addr, 32'h0);
        chk("R8", "reset full_flag", 32'(full_flag), 32'h0);
        chk("R6", "reset mem_we", 32'(mem_we), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        lo = 32'h1000; hi = 32'h10FF; st = 32'h100; en_a = 32'h118;
        tag = "R10"; do_reload();
        chk("R10", "reload to start", next_addr, 32'h100);

        // R2: any-write mode, data and size irrelevant
        tag = "R2"; mode = 4'b0001; we_cnt = 0;
        wr(0, 32'h1010, 32'hDEAD_BEEF, 2'd0);
        wr(1, 32'h1020, 32'h0, 2'd1);
        chk("R2", "record writes", 32'(we_cnt), 32'd4);

        // R5: inclusive window edges
        tag = "R5"; we_cnt = 0;
        wr(2, 32'h0FFF, 32'h1, 2'd2);
        wr(2, 32'h1000, 32'h1, 2'd2);
        wr(2, 32'h10FF, 32'h1, 2'd2);
        wr(2, 32'h1100, 32'h1, 2'd2);
        chk("R5", "record writes", 32'(we_cnt), 32'd4);

        // R7/R8: fourth record filled last slot, pointer wrapped
        chk("R7", "wrap to start", next_addr, 32'h100);
        chk("R8", "full after wrap", 32'(full_flag), 32'h1);
        tag = "R8"; fclr = 1'b1; step();
        chk("R8", "full cleared", 32'(full_flag), 32'h0);

        // R1: disabled source ignored
        tag = "R1"; en = 3'b101; we_cnt = 0;
        wr(1, 32'h1040, 32'h5, 2'd2);
        chk("R1", "disabled source writes", 32'(we_cnt), 32'd0);
        en = 3'b111;

        // R3/R4: check value with mode and mask
        tag = "R3"; mode = 4'b0010; chkv = 32'h1122_3344; bmask = 4'b0000; we_cnt = 0;
        wr(0, 32'h1050, 32'h1122_3344, 2'd2);
        wr(0, 32'h1050, 32'h1122_3345, 2'd2);
        wr(0, 32'h1050, 32'h1122_3344, 2'd1);
        chk("R3", "word mode writes", 32'(we_cnt), 32'd2);
        tag = "R4"; bmask = 4'b0001; we_cnt = 0;
        wr(0, 32'h1054, 32'h1122_33FF, 2'd2);
        wr(0, 32'h1054, 32'h1122_34FF, 2'd2);
        chk("R4", "masked byte writes", 32'(we_cnt), 32'd2);
        tag = "R3"; mode = 4'b1000; we_cnt = 0;
        wr(1, 32'h1058, 32'h1122_3300, 2'd0);
        chk("R3", "byte mode writes", 32'(we_cnt), 32'd2);
        mode = 4'b0100; we_cnt = 0;
        wr(2, 32'h105A, 32'h1122_3300, 2'd1);
        wr(2, 32'h105A, 32'h1122_3300, 2'd2);
        chk("R3", "half mode writes", 32'(we_cnt), 32'd2);
        bmask = '0;

        // R11: non-one-hot mode and zero enables
        tag = "R11"; mode = 4'b0011; we_cnt = 0;
        wr(0, 32'h1060, 32'h0, 2'd2);
        mode = 4'b0000;
        wr(0, 32'h1060, 32'h0, 2'd2);
        mode = 4'b0001; en = 3'b000;
        wr(0, 32'h1060, 32'h0, 2'd2);
        chk("R11", "no trigger writes", 32'(we_cnt), 32'd0);
        en = 3'b111;

        // R12: priority and drop during first word
        tag = "R12"; do_reload();
        v_in = 3'b111;
        a_in[0] = 32'h1070; a_in[1] = 32'h1074; a_in[2] = 32'h1078;
        s_in[0] = 2'd2; s_in[1] = 2'd1; s_in[2] = 2'd0;
        step();
        chk("R12", "winner address", mem_wdata, 32'h1070);
        v_in = '0; step();
        chk("R6", "info word", mem_wdata, 32'h0000_0020);
        chk("R6", "second word addr", mem_addr, 32'h104);
        step(); step();
        we_cnt = 0;
        v_in = 3'b100; a_in[2] = 32'h1080;
        repeat (3) step();
        v_in = '0; repeat (3) step();
        chk("R12", "back-to-back writes", 32'(we_cnt), 32'd4);

        // R10: reload aborts a record in progress
        tag = "R10"; we_cnt = 0;
        v_in = 3'b001; a_in[0] = 32'h1090; step();
        v_in = '0; reload = 1'b1; step();
        step(); step();
        chk("R10", "aborted record writes", 32'(we_cnt), 32'd1);
        chk("R10", "pointer at start", next_addr, 32'h100);

        // R9: stop at end with looping off
        tag = "R9"; wrap = 1'b0; st = 32'h200; en_a = 32'h208; do_reload();
        we_cnt = 0;
        for (int k = 0; k < 3; k++) wr(0, 32'h10A0 + 32'(k), 32'h0, 2'd2);
        chk("R9", "writes before stop", 32'(we_cnt), 32'd4);
        chk("R9", "pointer holds at end", next_addr, 32'h208);
        chk("R8", "full on stop", 32'(full_flag), 32'h1);
        do_reload();
        chk("R9", "reload leaves stop", next_addr, 32'h200);
        wrap = 1'b1;

        // constrained random mix
        tag = "R12"; st = 32'h400; en_a = 32'h438; chkv = 32'hA5C3_0F96;
        do_reload();
        for (int c = 0; c < 4000; c++) begin
            for (int s = 0; s < 3; s++) begin
                v_in[s] = ($urandom % 3) == 0;
                a_in[s] = 32'h0FF0 + ($urandom % 32'h120);
                s_in[s] = 2'($urandom % 4);
                d_in[s] = (($urandom % 2) == 0) ? (chkv ^ (32'($urandom % 2) << (8 * ($urandom % 4)))) : $urandom;
            end
            if (($urandom % 40) == 0) begin
                case ($urandom % 5)
                    0: mode = 4'b0001; 1: mode = 4'b0010; 2: mode = 4'b0100; 3: mode = 4'b1000;
                    default: mode = 4'($urandom);
                endcase
                bmask = 4'($urandom);
                en = (($urandom % 4) == 0) ? 3'($urandom) : 3'b111;
            end
            if (($urandom % 200) == 0) reload = 1'b1;
            if (($urandom % 50) == 0) fclr = 1'b1;
            if (($urandom % 300) == 0) wrap = ~wrap;
            if (mst == 3 && ($urandom % 20) == 0) reload = 1'b1;
            step();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule